// File: doc/BRIEF.md
# Register Rename Unit with Physical Tag Free List

This block gives destination registers new names as instructions dispatch in a small out-of-order core. A FIFO holds every physical tag that is not in use. A rename table holds, for each architectural register, the physical tag of its youngest in-flight producer, or records that no producer is in flight. A dispatching instruction that writes a result takes the tag at the head of the FIFO. The same cycle, the table entry for its destination is overwritten with that tag. Because each new write gets a fresh name, write-after-write and write-after-read conflicts go away. Each of the two source lookups returns either the producing physical tag or an indication that the value already sits in the architectural file.

Physical registers only hold results until commit. At commit the value moves to a separate architectural file, which is outside this block. The commit port gives the block the architectural/physical pair. If the table still points at that tag, the entry is dropped. The tag always goes back to the tail of the FIFO. There are more physical tags than architectural registers, and at reset the FIFO is full.

Top module: `reg_rename`

## Requirements
- R1: After reset, `disp_ready` is 1 and every architectural register reads as `in_arf`=1 with tag 0. Tags are then handed out in ascending order 0,1,…,PHYS_REGS-1.
- R2: When `disp_valid`=1, `disp_has_dst`=1 and `disp_ready`=1, the allocation takes effect on the next clock edge. `disp_dst_phys` shows the tag at the head of the free list, and that tag is removed from the list.
- R3: After an allocation, a lookup of that architectural register returns the new tag with `in_arf`=0. It keeps doing so until a newer rename or a matching commit changes the entry. A source whose register is in the architectural file returns tag 0 and `in_arf`=1.
- R4: A source lookup in the same cycle as a rename of the same architectural register returns the mapping that held before that rename.
- R5: `disp_ready` is 0 exactly when the free list is empty. A dispatch presented while it is 0 takes no tag and leaves the table unchanged.
- R6: A dispatch with `disp_has_dst`=0, or with `disp_valid`=0, takes no tag and does not change the table.
- R7: A commit pushes `cmt_phys` to the tail of the free list. A commit and an allocation in the same cycle both take effect, and the tag count moves by +1 and −1.
- R8: A commit clears the table entry of `cmt_arch` only when that entry holds `cmt_phys`. Otherwise the younger mapping is kept.
- R9: When an allocation and a commit target the same architectural register in one cycle, the new mapping is the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | An instruction is presented for dispatch |
| disp_has_dst | input | 1 | The dispatching instruction writes a destination |
| disp_dst_arch | input | AW | Destination architectural register |
| disp_src0_arch | input | AW | First source architectural register |
| disp_src1_arch | input | AW | Second source architectural register |
| disp_ready | output | 1 | Free list not empty; dispatch can proceed |
| disp_dst_phys | output | TW | Physical tag given to the destination |
| src0_phys | output | TW | Producer tag of source 0 (0 when in architectural file) |
| src0_in_arf | output | 1 | Source 0 value is in the architectural file |
| src1_phys | output | TW | Producer tag of source 1 (0 when in architectural file) |
| src1_in_arf | output | 1 | Source 1 value is in the architectural file |
| cmt_valid | input | 1 | An instruction with a destination commits |
| cmt_arch | input | AW | Architectural register of the committing instruction |
| cmt_phys | input | TW | Physical tag being released |

## Verification
The assertions check on every cycle that the tag count moves by exactly the commits minus the allocations and never exceeds the pool size. They also check that an empty list lowers `disp_ready`, that an allocation lands in the table, that a commit clears only a matching entry, and that a same-cycle rename wins over a clear. Only the bench scenarios show that tags come out in FIFO order, both from reset and after recycling. The same holds for old-mapping lookups in a same-cycle rename, and for stalled or destination-less dispatches leaving no trace. A long mixed stream of dispatches and in-order commits is compared against a reference model that is kept separately in the bench.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Index width for n items; never less than one bit.
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // A table entry is still the one a retiring instruction created.
  function automatic logic still_current(input logic        held_valid,
                                         input logic [31:0] held_tag,
                                         input logic [31:0] retire_tag);
    return held_valid && (held_tag == retire_tag);
  endfunction

  // Free-list occupancy after one cycle of returns and takes.
  function automatic int next_count(input int cnt, input logic ret, input logic take);
    return cnt + int'(ret) - int'(take);
  endfunction

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  localparam int PW   = rn_pkg::idx_bits(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  output logic [TW-1:0] head_tag,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [TW-1:0] slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= TW'(i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(DEPTH);
    end else begin
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push) begin
        slots[wr_ptr] <= push_tag;
        wr_ptr        <= bump(wr_ptr);
      end
      count <= CW'(rn_pkg::next_count(int'(count), push, pop));
    end
  end

  assign head_tag = slots[rd_ptr];
  assign empty    = (count == '0);

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH = 8,
  parameter int TW   = 4,
  localparam int AW  = rn_pkg::idx_bits(ARCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_arch,
  input  logic [TW-1:0]      wr_tag,
  input  logic               clr_en,
  input  logic [AW-1:0]      clr_arch,
  input  logic [TW-1:0]      clr_tag,
  input  logic [AW-1:0]      rd0_arch,
  input  logic [AW-1:0]      rd1_arch,
  output logic [TW-1:0]      rd0_tag,
  output logic               rd0_in_arf,
  output logic [TW-1:0]      rd1_tag,
  output logic               rd1_in_arf,
  output logic               clr_hit,
  output logic [ARCH-1:0]    valid_vec,
  output logic [ARCH*TW-1:0] tag_flat
);

  logic [TW-1:0] tags [ARCH];

  assign clr_hit = clr_en && rn_pkg::still_current(valid_vec[clr_arch],
                                                   32'(tags[clr_arch]),
                                                   32'(clr_tag));

  for (genvar g = 0; g < ARCH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tags[g]      <= '0;
      end else if (wr_en && (wr_arch == AW'(g))) begin
        valid_vec[g] <= 1'b1;
        tags[g]      <= wr_tag;
      end else if (clr_hit && (clr_arch == AW'(g))) begin
        valid_vec[g] <= 1'b0;
      end
    end
    assign tag_flat[g*TW +: TW] = tags[g];
  end

  assign rd0_in_arf = !valid_vec[rd0_arch];
  assign rd0_tag    = valid_vec[rd0_arch] ? tags[rd0_arch] : '0;
  assign rd1_in_arf = !valid_vec[rd1_arch];
  assign rd1_tag    = valid_vec[rd1_arch] ? tags[rd1_arch] : '0;

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = rn_pkg::idx_bits(ARCH_REGS),
  localparam int TW = rn_pkg::idx_bits(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic          disp_has_dst,
  input  logic [AW-1:0] disp_dst_arch,
  input  logic [AW-1:0] disp_src0_arch,
  input  logic [AW-1:0] disp_src1_arch,
  output logic          disp_ready,
  output logic [TW-1:0] disp_dst_phys,
  output logic [TW-1:0] src0_phys,
  output logic          src0_in_arf,
  output logic [TW-1:0] src1_phys,
  output logic          src1_in_arf,
  input  logic          cmt_valid,
  input  logic [AW-1:0] cmt_arch,
  input  logic [TW-1:0] cmt_phys
);

  localparam int CW = $clog2(PHYS_REGS + 1);

  // Named internal events, observed by the bound checker.
  logic                     fl_empty;
  logic [CW-1:0]            fl_count;
  logic                     alloc_fire;
  logic                     clr_hit;
  logic [ARCH_REGS-1:0]     map_valid;
  logic [ARCH_REGS*TW-1:0]  map_tags;

  assign disp_ready = !fl_empty;
  assign alloc_fire = disp_valid && disp_has_dst && !fl_empty;

  rn_freelist #(.DEPTH(PHYS_REGS), .TW(TW)) u_freelist (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc_fire),
    .push     (cmt_valid),
    .push_tag (cmt_phys),
    .head_tag (disp_dst_phys),
    .empty    (fl_empty),
    .count    (fl_count)
  );

  rn_map_table #(.ARCH(ARCH_REGS), .TW(TW)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (alloc_fire),
    .wr_arch    (disp_dst_arch),
    .wr_tag     (disp_dst_phys),
    .clr_en     (cmt_valid),
    .clr_arch   (cmt_arch),
    .clr_tag    (cmt_phys),
    .rd0_arch   (disp_src0_arch),
    .rd1_arch   (disp_src1_arch),
    .rd0_tag    (src0_phys),
    .rd0_in_arf (src0_in_arf),
    .rd1_tag    (src1_phys),
    .rd1_in_arf (src1_in_arf),
    .clr_hit    (clr_hit),
    .valid_vec  (map_valid),
    .tag_flat   (map_tags)
  );

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = rn_pkg::idx_bits(ARCH_REGS),
  localparam int TW = rn_pkg::idx_bits(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_fire,
  input logic                    disp_ready,
  input logic [AW-1:0]           disp_dst_arch,
  input logic [TW-1:0]           disp_dst_phys,
  input logic                    cmt_valid,
  input logic [AW-1:0]           cmt_arch,
  input logic                    clr_hit,
  input logic [CW-1:0]           fl_count,
  input logic [ARCH_REGS-1:0]    map_valid,
  input logic [ARCH_REGS*TW-1:0] map_tags
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  logic same_arch;
  assign same_arch = alloc_fire && cmt_valid && (disp_dst_arch == cmt_arch);

  AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count == '0) |-> !disp_ready); // R5

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fl_count) <= PHYS_REGS); // R7

  AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (int'(fl_count) == int'($past(fl_count)) + int'($past(cmt_valid)) - int'($past(alloc_fire)))); // R7

  AST_RENAME_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (map_valid[$past(disp_dst_arch)] &&
                    map_tags[$past(disp_dst_arch)*TW +: TW] == $past(disp_dst_phys))); // R3

  AST_STALE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !clr_hit && !same_arch) |=>
      (map_valid[$past(cmt_arch)] == $past(map_valid[cmt_arch]))); // R8

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && clr_hit && !same_arch) |=> !map_valid[$past(cmt_arch)]); // R8

  AST_NEW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    same_arch |=> (map_valid[$past(cmt_arch)] &&
                   map_tags[$past(cmt_arch)*TW +: TW] == $past(disp_dst_phys))); // R9

endmodule

bind reg_rename rn_checker #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_rn_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_fire    (alloc_fire),
  .disp_ready    (disp_ready),
  .disp_dst_arch (disp_dst_arch),
  .disp_dst_phys (disp_dst_phys),
  .cmt_valid     (cmt_valid),
  .cmt_arch      (cmt_arch),
  .clr_hit       (clr_hit),
  .fl_count      (fl_count),
  .map_valid     (map_valid),
  .map_tags      (map_tags)
);

// File: tb/test_reg_rename.sv
module test_reg_rename;

  localparam int NA = 8;
  localparam int NP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0, disp_has_dst = 1'b0;
  logic [2:0] disp_dst_arch = '0, disp_src0_arch = '0, disp_src1_arch = '0;
  logic       disp_ready;
  logic [3:0] disp_dst_phys, src0_phys, src1_phys;
  logic       src0_in_arf, src1_in_arf;
  logic       cmt_valid = 1'b0;
  logic [2:0] cmt_arch = '0;
  logic [3:0] cmt_phys = '0;

  always #10 clk = ~clk; // 50 MHz

  reg_rename #(.ARCH_REGS(NA), .PHYS_REGS(NP)) i_reg_rename (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_has_dst(disp_has_dst),
    .disp_dst_arch(disp_dst_arch), .disp_src0_arch(disp_src0_arch),
    .disp_src1_arch(disp_src1_arch), .disp_ready(disp_ready),
    .disp_dst_phys(disp_dst_phys), .src0_phys(src0_phys), .src0_in_arf(src0_in_arf),
    .src1_phys(src1_phys), .src1_in_arf(src1_in_arf),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_phys(cmt_phys)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model
  int fl_q[$];
  bit m_valid[NA];
  int m_tag[NA];
  int inf_arch[$];
  int inf_phys[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    fl_q.delete();
    for (int i = 0; i < NP; i++) fl_q.push_back(i);
    for (int a = 0; a < NA; a++) begin m_valid[a] = 0; m_tag[a] = 0; end
    inf_arch.delete();
    inf_phys.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    disp_valid = 0; disp_has_dst = 0; cmt_valid = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive at negedge, compare outputs, update model at posedge.
  task automatic cycle(input bit dv, input bit hd, input int da, input int s0, input int s1,
                       input bit cv, input int ca, input int cp, input string sreq);
    bit fire;
    @(negedge clk);
    disp_valid = dv; disp_has_dst = hd; disp_dst_arch = 3'(da);
    disp_src0_arch = 3'(s0); disp_src1_arch = 3'(s1);
    cmt_valid = cv; cmt_arch = 3'(ca); cmt_phys = 4'(cp);
    #1;
    chk("R5", "disp_ready", int'(disp_ready), int'(fl_q.size() > 0));
    fire = dv && hd && (fl_q.size() > 0);
    if (fire) chk("R2", "disp_dst_phys", int'(disp_dst_phys), fl_q[0]);
    chk(sreq, "src0_in_arf", int'(src0_in_arf), int'(!m_valid[s0]));
    chk(sreq, "src0_phys", int'(src0_phys), m_valid[s0] ? m_tag[s0] : 0);
    chk(sreq, "src1_in_arf", int'(src1_in_arf), int'(!m_valid[s1]));
    chk(sreq, "src1_phys", int'(src1_phys), m_valid[s1] ? m_tag[s1] : 0);
    @(posedge clk);
    if (cv) begin
      fl_q.push_back(cp);
      if (m_valid[ca] && m_tag[ca] == cp) m_valid[ca] = 0;
    end
    if (fire) begin
      int t;
      t = fl_q.pop_front();
      m_valid[da] = 1;
      m_tag[da] = t;
      inf_arch.push_back(da);
      inf_phys.push_back(t);
    end
    @(negedge clk);
    disp_valid = 0; cmt_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: reset state of lookups and ready.
    for (int a = 0; a < NA; a++) cycle(0, 0, 0, a, (a + 3) % NA, 0, 0, 0, "R1");
    #1 chk("R1", "disp_ready after reset", int'(disp_ready), 1);

    // R6: no destination / not valid takes nothing.
    cycle(1, 0, 2, 2, 2, 0, 0, 0, "R6");
    cycle(0, 1, 3, 3, 3, 0, 0, 0, "R6");
    cycle(0, 0, 0, 2, 3, 0, 0, 0, "R6");
    #1 chk("R6", "head tag unchanged", int'(disp_dst_phys), 0);

    // R1/R2/R4: drain pool in ascending order; sources read the older mapping.
    for (int i = 0; i < NP; i++) begin
      #1 chk("R1", "ascending tag", int'(disp_dst_phys), i);
      cycle(1, 1, i % NA, i % NA, (i + 1) % NA, 0, 0, 0, "R4");
    end

    // R5: empty pool stalls; stalled dispatch leaves table alone.
    cycle(1, 1, 5, 5, 6, 0, 0, 0, "R5");
    cycle(1, 1, 5, 5, 6, 0, 0, 0, "R5");
    #1 chk("R5", "arch5 tag after stall", int'(src0_phys), 13);

    // R8: stale commit (arch0 now holds 8) keeps mapping; returns tag 0.
    cycle(0, 0, 0, 0, 1, 1, 0, 0, "R8");
    cycle(0, 0, 0, 0, 1, 0, 0, 0, "R8");
    #1 chk("R8", "arch0 still tag 8", int'(src0_phys), 8);
    chk("R7", "ready after return", int'(disp_ready), 1);

    // R7/R9: commit arch0/tag8 with a same-cycle rename of arch0 (takes tag 0).
    cycle(1, 1, 0, 0, 0, 1, 0, 8, "R9");
    cycle(0, 0, 0, 0, 1, 0, 0, 0, "R9");
    #1 chk("R9", "arch0 holds new tag", int'(src0_phys), 0);
    chk("R9", "arch0 not in arf", int'(src0_in_arf), 0);
    chk("R7", "returned tag at head", int'(disp_dst_phys), 8);

    // R8: matching commit clears (arch1 held tag 9).
    cycle(0, 0, 0, 1, 1, 1, 1, 9, "R8");
    cycle(0, 0, 0, 1, 2, 0, 0, 0, "R8");
    #1 chk("R8", "arch1 in arf after clear", int'(src0_in_arf), 1);

    // Mixed stream with in-order commits against the model.
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      bit cv;
      int ca, cp;
      cv = (inf_arch.size() > 0) && ($urandom % 2 == 0);
      ca = 0; cp = 0;
      if (cv) begin
        ca = inf_arch.pop_front();
        cp = inf_phys.pop_front();
      end
      cycle($urandom % 4 != 0, $urandom % 4 != 0, $urandom % NA, $urandom % NA,
            $urandom % NA, cv, ca, cp, "R3");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule